// File: doc/BRIEF.md
# Vector element slide engine

This unit moves the elements of one vector register up or down by an offset and writes the result into a local copy of a destination register. It handles four variants. Slide-up and slide-down move by a full-width scalar offset or by a small immediate offset. Slide-one-up and slide-one-down move by exactly one element and put a scalar value into the end that is left empty. Per-element masking is honoured. Every element from the active length up to the register's element capacity is cleared.

A sequencer starts the unit with a one-cycle `start`. At that edge the unit captures the decoded operation fields, the source vector, the mask, the scalar, the active length, the element width, the element capacity and the old destination contents. It then visits each element index in turn, one per clock, from 0 to capacity minus 1. Each write is reported on a write stream and is also applied to the destination image on `dst_vec`. `done` pulses once when the operation is over. An operation with an illegal encoding or illegal register use sets `illegal` together with `done` and writes nothing.

Top module: `slide_engine`

## Requirements
- R1: After synchronous active-low reset, `busy`, `done`, `illegal` and `wr_valid` are 0 and `dst_vec` is all zeros.
- R2: Slide-up (funct6 001110, funct3 100 or 011) writes element i from source element i-off for off <= i < vl. Elements below off are not written.
- R3: Slide-down (funct6 001111, funct3 100 or 011) writes element i from source element i+off for i < vl. If i+off is at or above the element capacity, the value written is zero. The sum is formed without wrap-around.
- R4: Slide-one-up (funct6 001110, funct3 110) writes the scalar into element 0 and source element i-1 into element i for 0 < i < vl.
- R5: Slide-one-down (funct6 001111, funct3 110) writes source element i+1 into element i for i < vl-1 and writes the scalar into element vl-1.
- R6: When `op_vm` is 0 and `mask_vec` bit i is 0 for some i < vl, element i is not written and keeps its value from `dst_init`.
- R7: Every element index from vl up to capacity-1 is written with zero, whatever the mask says.
- R8: `sew` selects the element width: 0 for 8 bits, 1 for 16, 2 for 32, 3 for 64. Element i occupies bits [i*w +: w] of each vector. The inserted scalar is cut down to the low w bits.
- R9: The operation is illegal if it is an up variant with `vd_sel` equal to `vs2_sel`, or if any variant has `op_vm`=0 and `vd_sel`=0. An illegal operation raises `illegal` in the same cycle as `done` and makes no write.
- R10: An operation is accepted only when the major opcode is 1010111, funct6 is 001110 or 001111, and funct3 is 100 (scalar offset), 011 (5-bit immediate, zero-extended) or 110 (slide by one). Any other encoding is illegal as in R9.
- R11: Writes appear in increasing index order, at most one per cycle. `done` is high for exactly one cycle, and that cycle is the one after the last element index is processed. A `start` that arrives while `busy` is 1 is ignored.
- R12: A slide-up whose offset is at or above vl writes no active element and only clears the tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Starts an operation when idle; operands are captured on this edge |
| op_major | input | 7 | Major opcode field |
| op_funct6 | input | 6 | Direction field |
| op_funct3 | input | 3 | Offset-form field |
| op_vm | input | 1 | 1 = unmasked, 0 = use mask_vec |
| vd_sel | input | 5 | Destination register number |
| vs2_sel | input | 5 | Source register number |
| imm5 | input | 5 | Immediate offset |
| scalar | input | XLEN | Scalar offset or inserted value |
| vl | input | CNT_W | Active element count |
| sew | input | 2 | Element width code |
| elem_max | input | CNT_W | Element capacity of the register |
| src_vec | input | VLEN | Source vector |
| mask_vec | input | VLEN/8 | Mask, one bit per element |
| dst_init | input | VLEN | Old destination contents |
| busy | output | 1 | Operation in progress |
| wr_valid | output | 1 | An element write is reported this cycle |
| wr_idx | output | CNT_W | Index of the written element |
| wr_data | output | 64 | Written value, zero-extended |
| dst_vec | output | VLEN | Destination image |
| done | output | 1 | One-cycle end-of-operation pulse |
| illegal | output | 1 | Operation was rejected; valid with done |

## Verification
A wrong index counter or a wrong latched offset shows up on the write stream at once. The index or data of the very next reported write is wrong, and the scoreboard catches this in the cycle it appears, before `done`. A wrong mask or capacity decision shows up as a missing or extra write, and that also shows at the first element it affects. A corrupted destination image shows up only on `dst_vec`, which is compared in full when `done` arrives. A wrong legality decision shows up within two cycles of `start` as an early `done` with `illegal` set, or as a missing `illegal`.

// File: rtl/slide_pkg.sv
// Package: shared encodings and helpers for the slide engine.
// Assumes elements are at most 64 bits wide.
package slide_pkg;

    localparam logic [6:0] OPC_VECTOR = 7'b1010111;
    localparam logic [5:0] DIR_UP     = 6'b001110;
    localparam logic [5:0] DIR_DOWN   = 6'b001111;
    localparam logic [2:0] FORM_REG   = 3'b100;
    localparam logic [2:0] FORM_IMM   = 3'b011;
    localparam logic [2:0] FORM_ONE   = 3'b110;

    typedef enum logic [1:0] {
        SK_UP    = 2'd0,
        SK_DOWN  = 2'd1,
        SK_UP1   = 2'd2,
        SK_DOWN1 = 2'd3
    } slide_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } slide_state_e;

    // Returns a mask covering the low bits of one element of the given width code.
    function automatic logic [63:0] width_mask(input logic [1:0] sew);
        case (sew)
            2'd0:    width_mask = 64'h0000_0000_0000_00FF;
            2'd1:    width_mask = 64'h0000_0000_0000_FFFF;
            2'd2:    width_mask = 64'h0000_0000_FFFF_FFFF;
            default: width_mask = 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/slide_decode.sv
// Module: slide_decode
// Turns the instruction fields into a slide variant and an offset, and
// decides whether the operation is legal. Purely combinational.
// Assumes register grouping is one register, so overlap with v0 means vd == 0.
module slide_decode
    import slide_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [6:0]      major_i,
    input  logic [5:0]      funct6_i,
    input  logic [2:0]      funct3_i,
    input  logic            vm_i,
    input  logic [4:0]      vd_i,
    input  logic [4:0]      vs2_i,
    input  logic [4:0]      imm_i,
    input  logic [XLEN-1:0] scalar_i,
    output slide_kind_e     kind_o,
    output logic [XLEN-1:0] offset_o,
    output logic            legal_o
);

    logic is_up;
    logic is_down;
    logic form_ok;
    logic is_one;

    // Classifies the encoding and checks the register-use rules.
    always_comb begin
        is_up   = (funct6_i == DIR_UP);
        is_down = (funct6_i == DIR_DOWN);
        is_one  = (funct3_i == FORM_ONE);
        form_ok = (funct3_i == FORM_REG) || (funct3_i == FORM_IMM) || is_one;

        if (is_up) kind_o = is_one ? SK_UP1 : SK_UP;
        else       kind_o = is_one ? SK_DOWN1 : SK_DOWN;

        offset_o = (funct3_i == FORM_IMM) ? XLEN'(imm_i) : scalar_i;

        legal_o = (major_i == OPC_VECTOR) && (is_up || is_down) && form_ok
                  && !(is_up && (vd_i == vs2_i))
                  && !(!vm_i && (vd_i == 5'd0));
    end

endmodule

// File: rtl/slide_elem_pick.sv
// Module: slide_elem_pick
// Reads element idx of width code sew out of a flat vector, zero-extended
// to 64 bits. An index past the end of the vector reads as zero.
module slide_elem_pick
    import slide_pkg::*;
#(
    parameter int VLEN  = 256,
    parameter int IDX_W = 6
) (
    input  logic [VLEN-1:0]  vec_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [1:0]       sew_i,
    output logic [63:0]      elem_o
);

    localparam int SH_W = IDX_W + 6;

    logic [SH_W-1:0] bit_sh;
    logic [VLEN-1:0] shifted;

    // Aligns the wanted element to bit 0 and masks it to its width.
    always_comb begin
        bit_sh  = SH_W'({idx_i, 3'b000}) << sew_i;
        shifted = vec_i >> bit_sh;
        elem_o  = shifted[63:0] & width_mask(sew_i);
    end

endmodule

// File: rtl/slide_lane_calc.sv
// Module: slide_lane_calc
// For the current element index, decides whether the destination element is
// written and with what value: variant mapping, masking, out-of-range zero
// and tail clearing. Assumes vl <= emax and idx < emax.
module slide_lane_calc
    import slide_pkg::*;
#(
    parameter int VLEN  = 256,
    parameter int XLEN  = 64,
    parameter int CNT_W = 6
) (
    input  slide_kind_e     kind_i,
    input  logic [CNT_W-1:0] idx_i,
    input  logic [CNT_W-1:0] vl_i,
    input  logic [CNT_W-1:0] emax_i,
    input  logic [XLEN-1:0]  offset_i,
    input  logic             vm_i,
    input  logic             mbit_i,
    input  logic [XLEN-1:0]  scalar_i,
    input  logic [1:0]       sew_i,
    input  logic [VLEN-1:0]  src_i,
    output logic             we_o,
    output logic [63:0]      wdata_o
);

    logic [CNT_W-1:0] src_idx;
    logic [63:0]      src_elem;
    logic [XLEN:0]    down_sum;
    logic             down_past;
    logic             up_reach;
    logic             active;
    logic             last;
    logic [63:0]      ins_val;

    // Works out the source index and the range conditions for this index.
    always_comb begin
        down_sum  = {1'b0, offset_i} + (XLEN+1)'(idx_i);
        down_past = down_sum >= (XLEN+1)'(emax_i);
        up_reach  = offset_i <= XLEN'(idx_i);
        active    = idx_i < vl_i;
        last      = idx_i == (vl_i - CNT_W'(1));
        ins_val   = 64'(scalar_i) & width_mask(sew_i);
        case (kind_i)
            SK_UP:   src_idx = idx_i - CNT_W'(offset_i);
            SK_DOWN: src_idx = down_sum[CNT_W-1:0];
            SK_UP1:  src_idx = idx_i - CNT_W'(1);
            default: src_idx = idx_i + CNT_W'(1);
        endcase
    end

    slide_elem_pick #(
        .VLEN  (VLEN),
        .IDX_W (CNT_W)
    ) pick_i (
        .vec_i  (src_i),
        .idx_i  (src_idx),
        .sew_i  (sew_i),
        .elem_o (src_elem)
    );

    // Chooses write enable and data from the variant, mask and tail rules.
    always_comb begin
        we_o    = 1'b0;
        wdata_o = 64'd0;
        if (!active) begin
            we_o = 1'b1;
        end else if (vm_i || mbit_i) begin
            case (kind_i)
                SK_UP: begin
                    we_o    = up_reach;
                    wdata_o = src_elem;
                end
                SK_DOWN: begin
                    we_o    = 1'b1;
                    wdata_o = down_past ? 64'd0 : src_elem;
                end
                SK_UP1: begin
                    we_o    = 1'b1;
                    wdata_o = (idx_i == '0) ? ins_val : src_elem;
                end
                default: begin
                    we_o    = 1'b1;
                    wdata_o = last ? ins_val : src_elem;
                end
            endcase
        end
    end

endmodule

// File: rtl/slide_engine.sv
// Module: slide_engine (top)
// Runs one slide operation over a local destination image: captures the
// operands on start, visits one element index per clock from 0 to
// elem_max-1, reports each write, then pulses done. Illegal operations skip
// straight to done with illegal set. Assumes elem_max * element width <= VLEN
// and vl <= elem_max.
module slide_engine
    import slide_pkg::*;
#(
    parameter int VLEN = 256,
    parameter int XLEN = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [6:0]             op_major,
    input  logic [5:0]             op_funct6,
    input  logic [2:0]             op_funct3,
    input  logic                   op_vm,
    input  logic [4:0]             vd_sel,
    input  logic [4:0]             vs2_sel,
    input  logic [4:0]             imm5,
    input  logic [XLEN-1:0]        scalar,
    input  logic [$clog2(VLEN/8+1)-1:0] vl,
    input  logic [1:0]             sew,
    input  logic [$clog2(VLEN/8+1)-1:0] elem_max,
    input  logic [VLEN-1:0]        src_vec,
    input  logic [VLEN/8-1:0]      mask_vec,
    input  logic [VLEN-1:0]        dst_init,
    output logic                   busy,
    output logic                   wr_valid,
    output logic [$clog2(VLEN/8+1)-1:0] wr_idx,
    output logic [63:0]            wr_data,
    output logic [VLEN-1:0]        dst_vec,
    output logic                   done,
    output logic                   illegal
);

    localparam int MAX_ELEMS = VLEN / 8;
    localparam int CNT_W     = $clog2(MAX_ELEMS + 1);
    localparam int SH_W      = CNT_W + 6;

    slide_state_e         state_q;
    logic [CNT_W-1:0]     idx_q;
    slide_kind_e          kind_q;
    logic [XLEN-1:0]      off_q;
    logic                 vm_q;
    logic [MAX_ELEMS-1:0] mask_q;
    logic [XLEN-1:0]      scalar_q;
    logic [CNT_W-1:0]     vl_q;
    logic [CNT_W-1:0]     emax_q;
    logic [1:0]           sew_q;
    logic [VLEN-1:0]      src_q;
    logic [VLEN-1:0]      dst_q;
    logic                 ill_q;
    logic                 wr_valid_q;
    logic [CNT_W-1:0]     wr_idx_q;
    logic [63:0]          wr_data_q;
    logic                 done_q;
    logic                 illegal_q;

    slide_kind_e          dec_kind;
    logic [XLEN-1:0]      dec_off;
    logic                 dec_legal;
    logic                 lane_we;
    logic [63:0]          lane_data;
    logic [MAX_ELEMS-1:0] mask_sh;
    logic                 mask_bit;
    logic [SH_W-1:0]      put_sh;
    logic [VLEN-1:0]      put_mask;
    logic [VLEN-1:0]      dst_next;

    slide_decode #(
        .XLEN (XLEN)
    ) decode_i (
        .major_i  (op_major),
        .funct6_i (op_funct6),
        .funct3_i (op_funct3),
        .vm_i     (op_vm),
        .vd_i     (vd_sel),
        .vs2_i    (vs2_sel),
        .imm_i    (imm5),
        .scalar_i (scalar),
        .kind_o   (dec_kind),
        .offset_o (dec_off),
        .legal_o  (dec_legal)
    );

    // Selects the mask bit of the element being visited.
    always_comb begin
        mask_sh  = mask_q >> idx_q;
        mask_bit = mask_sh[0];
    end

    slide_lane_calc #(
        .VLEN  (VLEN),
        .XLEN  (XLEN),
        .CNT_W (CNT_W)
    ) lane_i (
        .kind_i   (kind_q),
        .idx_i    (idx_q),
        .vl_i     (vl_q),
        .emax_i   (emax_q),
        .offset_i (off_q),
        .vm_i     (vm_q),
        .mbit_i   (mask_bit),
        .scalar_i (scalar_q),
        .sew_i    (sew_q),
        .src_i    (src_q),
        .we_o     (lane_we),
        .wdata_o  (lane_data)
    );

    // Merges the computed element into the destination image.
    always_comb begin
        put_sh   = SH_W'({idx_q, 3'b000}) << sew_q;
        put_mask = VLEN'(width_mask(sew_q)) << put_sh;
        dst_next = (dst_q & ~put_mask) | (VLEN'(lane_data) << put_sh);
    end

    // Sequencer: operand capture, per-element stepping and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            idx_q      <= '0;
            kind_q     <= SK_UP;
            off_q      <= '0;
            vm_q       <= 1'b1;
            mask_q     <= '0;
            scalar_q   <= '0;
            vl_q       <= '0;
            emax_q     <= '0;
            sew_q      <= 2'd0;
            src_q      <= '0;
            dst_q      <= '0;
            ill_q      <= 1'b0;
            wr_valid_q <= 1'b0;
            wr_idx_q   <= '0;
            wr_data_q  <= '0;
            done_q     <= 1'b0;
            illegal_q  <= 1'b0;
        end else begin
            wr_valid_q <= 1'b0;
            done_q     <= 1'b0;
            illegal_q  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        kind_q   <= dec_kind;
                        off_q    <= dec_off;
                        vm_q     <= op_vm;
                        mask_q   <= mask_vec;
                        scalar_q <= scalar;
                        vl_q     <= vl;
                        emax_q   <= elem_max;
                        sew_q    <= sew;
                        src_q    <= src_vec;
                        dst_q    <= dst_init;
                        idx_q    <= '0;
                        ill_q    <= !dec_legal;
                        state_q  <= (!dec_legal || elem_max == '0) ? ST_FIN : ST_RUN;
                    end
                end
                ST_RUN: begin
                    wr_valid_q <= lane_we;
                    wr_idx_q   <= idx_q;
                    wr_data_q  <= lane_data;
                    if (lane_we) dst_q <= dst_next;
                    idx_q <= idx_q + CNT_W'(1);
                    if (idx_q == emax_q - CNT_W'(1)) state_q <= ST_FIN;
                end
                default: begin
                    done_q    <= 1'b1;
                    illegal_q <= ill_q;
                    state_q   <= ST_IDLE;
                end
            endcase
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign wr_valid = wr_valid_q;
    assign wr_idx   = wr_idx_q;
    assign wr_data  = wr_data_q;
    assign dst_vec  = dst_q;
    assign done     = done_q;
    assign illegal  = illegal_q;

endmodule

// File: rtl/slide_engine_chk.sv
// Module: slide_engine_chk
// Protocol and tail checks on the slide engine's ports, bound to every
// instance of the top module.
module slide_engine_chk #(
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             illegal,
    input logic             wr_valid,
    input logic [CNT_W-1:0] wr_idx,
    input logic [63:0]      wr_data,
    input logic [CNT_W-1:0] vl_lat
);

    // R1: the first cycle out of reset is quiet
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!done && !wr_valid && !busy && !illegal));

    // R11: done lasts a single cycle
    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: no write is reported once the unit is idle
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !wr_valid);

    // R11: back-to-back writes go to increasing indices
    a_r11_index_order: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && $past(wr_valid)) |-> (wr_idx > $past(wr_idx)));

    // R7: tail writes carry zero
    a_r7_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && (wr_idx >= vl_lat)) |-> (wr_data == 64'd0));

    // R9: illegal is only reported together with done
    a_r9_flag_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> done);

    // R9: a rejected operation made no write just before finishing
    a_r9_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (done && illegal) |-> !$past(wr_valid));

endmodule

bind slide_engine slide_engine_chk #(
    .CNT_W (CNT_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .illegal  (illegal),
    .wr_valid (wr_valid),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .vl_lat   (vl_q)
);

// File: tb/slide_engine_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver task models each operation and queues the
// expected writes; the monitor pops and compares them as writes appear.
module slide_engine_tb_top;

    localparam int VLEN  = 256;
    localparam int XLEN  = 64;
    localparam int CNT_W = 6;

    typedef struct packed {
        logic [CNT_W-1:0] idx;
        logic [63:0]      data;
    } wr_item_t;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [6:0]         op_major = '0;
    logic [5:0]         op_funct6 = '0;
    logic [2:0]         op_funct3 = '0;
    logic               op_vm = 1'b1;
    logic [4:0]         vd_sel = '0;
    logic [4:0]         vs2_sel = '0;
    logic [4:0]         imm5 = '0;
    logic [XLEN-1:0]    scalar = '0;
    logic [CNT_W-1:0]   vl = '0;
    logic [1:0]         sew = '0;
    logic [CNT_W-1:0]   elem_max = '0;
    logic [VLEN-1:0]    src_vec = '0;
    logic [VLEN/8-1:0]  mask_vec = '0;
    logic [VLEN-1:0]    dst_init = '0;
    logic               busy;
    logic               wr_valid;
    logic [CNT_W-1:0]   wr_idx;
    logic [63:0]        wr_data;
    logic [VLEN-1:0]    dst_vec;
    logic               done;
    logic               illegal;

    int       n_checks = 0;
    int       n_fail = 0;
    string    cur_req = "R1";
    wr_item_t exp_q[$];

    always #4 clk = ~clk;

    slide_engine #(.VLEN(VLEN), .XLEN(XLEN)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .op_major(op_major), .op_funct6(op_funct6), .op_funct3(op_funct3),
        .op_vm(op_vm), .vd_sel(vd_sel), .vs2_sel(vs2_sel), .imm5(imm5),
        .scalar(scalar), .vl(vl), .sew(sew), .elem_max(elem_max),
        .src_vec(src_vec), .mask_vec(mask_vec), .dst_init(dst_init),
        .busy(busy), .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_data(wr_data),
        .dst_vec(dst_vec), .done(done), .illegal(illegal)
    );

    task automatic check(input string req, input string what,
                         input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [VLEN-1:0] pattern(input int seed);
        logic [VLEN-1:0] v;
        for (int k = 0; k < VLEN / 8; k++) v[k*8 +: 8] = 8'((k * 37 + seed * 11 + 5) & 8'hFF);
        return v;
    endfunction

    // Monitor: compares every reported write with the head of the queue.
    always @(negedge clk) begin
        if (rst_n && wr_valid) begin
            if (exp_q.size() == 0) begin
                check(cur_req, "unexpected write", VLEN'({wr_idx, wr_data}), '1);
            end else begin
                wr_item_t it;
                it = exp_q.pop_front();
                check(cur_req, "write", VLEN'({wr_idx, wr_data}), VLEN'({it.idx, it.data}));
            end
        end
    end

    // Driver: models the operation, queues expected writes, runs and finishes it.
    task automatic run_op(input string req, input logic [6:0] maj, input logic [5:0] f6,
                          input logic [2:0] f3, input logic vm, input logic [4:0] vd,
                          input logic [4:0] vs2, input logic [4:0] imm,
                          input logic [63:0] scal, input int vlen_a, input int sw,
                          input int emax, input logic [VLEN-1:0] src,
                          input logic [31:0] msk, input logic [VLEN-1:0] init,
                          input bit exp_ill, input bit poke);
        int esz;
        logic [63:0] wm;
        logic [63:0] off;
        logic [VLEN-1:0] expv;
        bit up;
        bit one;
        esz  = 8 << sw;
        wm   = (sw == 3) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << esz) - 64'd1);
        up   = (f6 == 6'b001110);
        one  = (f3 == 3'b110);
        off  = (f3 == 3'b011) ? 64'(imm) : scal;
        expv = init;
        cur_req = req;
        exp_q.delete();
        if (!exp_ill) begin
            for (int i = 0; i < emax; i++) begin
                bit we;
                logic [63:0] val;
                we  = 1'b1;
                val = 64'd0;
                if (i < vlen_a) begin
                    if (!vm && !msk[i]) we = 1'b0;
                    else if (up && !one) begin
                        if (off > 64'(i)) we = 1'b0;
                        else val = 64'((src >> ((i - int'(off)) * esz))) & wm;
                    end else if (!up && !one) begin
                        if (off >= 64'(emax - i)) val = 64'd0;
                        else val = 64'((src >> ((i + int'(off)) * esz))) & wm;
                    end else if (up) begin
                        val = (i == 0) ? (scal & wm) : (64'((src >> ((i - 1) * esz))) & wm);
                    end else begin
                        val = (i == vlen_a - 1) ? (scal & wm) : (64'((src >> ((i + 1) * esz))) & wm);
                    end
                end
                if (we) begin
                    exp_q.push_back('{idx: CNT_W'(i), data: val});
                    expv = (expv & ~(VLEN'(wm) << (i * esz))) | (VLEN'(val) << (i * esz));
                end
            end
        end
        @(negedge clk);
        op_major = maj; op_funct6 = f6; op_funct3 = f3; op_vm = vm;
        vd_sel = vd; vs2_sel = vs2; imm5 = imm; scalar = scal;
        vl = CNT_W'(vlen_a); sew = 2'(sw); elem_max = CNT_W'(emax);
        src_vec = src; mask_vec = msk; dst_init = init;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            // R11: a second start while busy, with other operands, must be ignored
            check("R11", "busy after start", VLEN'(busy), VLEN'(1));
            src_vec = ~src; scalar = ~scal; dst_init = ~init; op_funct6 = ~f6;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        for (int k = 0; k < 400 && !done; k++) @(negedge clk);
        check("R11", "done seen", VLEN'(done), VLEN'(1));
        check(req, "queue drained", VLEN'(exp_q.size()), VLEN'(0));
        check(exp_ill ? "R9" : req, "illegal flag", VLEN'(illegal), VLEN'(exp_ill));
        check(req, "dst image", dst_vec, expv);
        @(negedge clk);
        check("R11", "done single cycle", VLEN'(done), VLEN'(0));
        exp_q.delete();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R11 watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", "busy", VLEN'(busy), VLEN'(0));
        check("R1", "done", VLEN'(done), VLEN'(0));
        check("R1", "wr_valid", VLEN'(wr_valid), VLEN'(0));
        check("R1", "illegal", VLEN'(illegal), VLEN'(0));
        check("R1", "dst_vec", dst_vec, '0);

        // R2/R8: slide-up by scalar 3, 8-bit elements, tail from 20
        run_op("R2", 7'b1010111, 6'b001110, 3'b100, 1'b1, 5'd2, 5'd3, 5'd0,
               64'd3, 20, 0, 32, pattern(1), 32'h0, pattern(2), 1'b0, 1'b0);
        // R3/R10: slide-down by immediate 5, 16-bit, runs past capacity
        run_op("R3", 7'b1010111, 6'b001111, 3'b011, 1'b1, 5'd8, 5'd16, 5'd5,
               64'hFFFF, 14, 1, 16, pattern(3), 32'h0, pattern(4), 1'b0, 1'b0);
        // R3: huge offset, every active element reads zero
        run_op("R3", 7'b1010111, 6'b001111, 3'b100, 1'b1, 5'd8, 5'd9, 5'd0,
               64'hFFFF_FFFF_FFFF_FFFE, 6, 2, 8, pattern(5), 32'h0, pattern(6), 1'b0, 1'b0);
        // R4/R8: slide-one-up, 32-bit, scalar truncated
        run_op("R4", 7'b1010111, 6'b001110, 3'b110, 1'b1, 5'd1, 5'd2, 5'd0,
               64'hDEAD_BEEF_1234_5678, 6, 2, 8, pattern(7), 32'h0, pattern(8), 1'b0, 1'b0);
        // R5/R8: slide-one-down, 64-bit
        run_op("R5", 7'b1010111, 6'b001111, 3'b110, 1'b1, 5'd3, 5'd3, 5'd0,
               64'hA5A5_0000_1111_2222, 3, 3, 4, pattern(9), 32'h0, pattern(10), 1'b0, 1'b0);
        // R5: slide-one-down with vl of one
        run_op("R5", 7'b1010111, 6'b001111, 3'b110, 1'b1, 5'd3, 5'd7, 5'd0,
               64'h0000_0000_0000_01C3, 1, 0, 32, pattern(11), 32'h0, pattern(12), 1'b0, 1'b0);
        // R6: masked slide-up, holes keep old destination values
        run_op("R6", 7'b1010111, 6'b001110, 3'b011, 1'b0, 5'd4, 5'd5, 5'd2,
               64'd0, 24, 0, 32, pattern(13), 32'hF0F0_5A3C, pattern(14), 1'b0, 1'b0);
        // R6/R7: masked slide-down, 16-bit, tail cleared despite zero mask bits
        run_op("R7", 7'b1010111, 6'b001111, 3'b100, 1'b0, 5'd6, 5'd6, 5'd0,
               64'd1, 10, 1, 16, pattern(15), 32'h0000_0135, pattern(16), 1'b0, 1'b0);
        // R12: slide-up offset beyond vl writes only the tail
        run_op("R12", 7'b1010111, 6'b001110, 3'b100, 1'b1, 5'd2, 5'd3, 5'd0,
               64'd100, 10, 0, 32, pattern(17), 32'h0, pattern(18), 1'b0, 1'b0);
        // R9: up variant with destination equal to source
        run_op("R9", 7'b1010111, 6'b001110, 3'b100, 1'b1, 5'd4, 5'd4, 5'd0,
               64'd1, 8, 0, 32, pattern(19), 32'h0, pattern(20), 1'b1, 1'b0);
        // R9: masked operation targeting v0
        run_op("R9", 7'b1010111, 6'b001111, 3'b100, 1'b0, 5'd0, 5'd4, 5'd0,
               64'd1, 8, 0, 32, pattern(21), 32'hFFFF_FFFF, pattern(22), 1'b1, 1'b0);
        // R10: unsupported funct3, wrong major opcode, wrong funct6
        run_op("R10", 7'b1010111, 6'b001110, 3'b000, 1'b1, 5'd2, 5'd3, 5'd0,
               64'd1, 8, 0, 32, pattern(23), 32'h0, pattern(24), 1'b1, 1'b0);
        run_op("R10", 7'b0010011, 6'b001111, 3'b100, 1'b1, 5'd2, 5'd3, 5'd0,
               64'd1, 8, 0, 32, pattern(25), 32'h0, pattern(26), 1'b1, 1'b0);
        run_op("R10", 7'b1010111, 6'b001101, 3'b100, 1'b1, 5'd2, 5'd3, 5'd0,
               64'd1, 8, 0, 32, pattern(27), 32'h0, pattern(28), 1'b1, 1'b0);
        // R9: down variant may use vd equal to vs2
        run_op("R9", 7'b1010111, 6'b001111, 3'b100, 1'b1, 5'd5, 5'd5, 5'd0,
               64'd2, 12, 0, 16, pattern(29), 32'h0, pattern(30), 1'b0, 1'b0);
        // R11: start while busy is ignored
        run_op("R11", 7'b1010111, 6'b001110, 3'b110, 1'b1, 5'd1, 5'd2, 5'd0,
               64'h77, 16, 0, 32, pattern(31), 32'h0, pattern(32), 1'b0, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule